// File: doc/BRIEF.md
# Winograd 3x3 Convolution Tile Engine

This block produces 2x2 output tiles of a stride-1, 3x3 convolution with the minimal-filtering method. A 4x4 input patch enters per input channel; consecutive patches of one spatial position form a group, and the last patch of the group is marked. Each patch is turned into the transform domain using additions and subtractions only. All output-channel lanes then use that transformed patch at the same time, and each lane multiplies it element by element with its own transformed kernel. The sixteen products of each lane are accumulated over the whole group. One output transform, again made of additions only, is applied when the group closes. Neighbouring patches overlap by two rows or columns, because the caller steps the 4x4 window by two.

Kernels are transformed offline. They are written through a load port, one 4x4 tile per (lane, channel-slot) pair. The engine does not handle strided convolution: a patch that requests stride 2 is refused and flagged. Data are 16-bit two's-complement fixed point. Loaded weight tiles are taken as scaled by 2^FRAC_BITS, and results are shifted back by the same amount and clamped to 16 bits.

Top module: `wino_tile_engine`

## Requirements
- R1: After a synchronous active-low reset, out_valid and stride_err are 0 and in_ready is 1.
- R2: For a one-patch group, lane L's output element (r,c), where element (r,c) sits at out_tile bits [((L*4)+r*2+c)*16 +: 16], equals (sum over i,j<3 of d[r+i][c+j]*k[i][j]) clamped to 16 bits. Here input element (r,c) sits at in_tile bits [(r*4+c)*16 +: 16], and the loaded weight tile is 2^FRAC_BITS * G k G^T with G rows [1,0,0], [1/2,1/2,1/2], [1/2,-1/2,1/2], [0,0,1], stored in the same element order.
- R3: In a group of N patches (N up to CIN_MAX), the n-th accepted patch (counting from 0) uses the weight slot w_chan = n. The output is the clamped sum of the N per-channel convolutions, and exactly one output tile is produced per group, when the patch with in_last = 1 is processed.
- R4: Every lane sees the same patch, and each lane uses only the weights written while w_lane held its index.
- R5: A result above 32767 comes out as 32767, and one below -32768 comes out as -32768.
- R6: A patch accepted with in_stride2 = 1 makes stride_err 1 for exactly the following cycle. It adds nothing to any accumulation, does not advance the slot count, and produces no output, even when in_last = 1.
- R7: While out_valid = 1 and out_ready = 0, out_valid stays 1 and out_tile stays unchanged. Later groups wait, in_ready drops once the internal stages are full, and no result is lost or reordered.
- R8: With the output free, out_valid rises on the second clock edge after the edge that accepts the last patch of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input patch present |
| in_ready | output | 1 | Engine can take a patch this cycle |
| in_tile | input | 16*DW | 4x4 input patch, element (r,c) at index r*4+c |
| in_last | input | 1 | Patch closes the channel group |
| in_stride2 | input | 1 | Patch requests stride 2 (refused) |
| w_we | input | 1 | Weight tile write strobe |
| w_lane | input | LB | Destination lane of the weight tile |
| w_chan | input | CB | Destination channel slot of the weight tile |
| w_tile | input | 16*DW | Transformed 4x4 weight tile |
| out_valid | output | 1 | Output tiles present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_tile | output | LANES*4*DW | 2x2 result per lane, lane-major |
| stride_err | output | 1 | One-cycle flag for a refused stride-2 patch |

## Verification
A wrong transform coefficient or a wrong lane-to-weight pairing shows up in the first output tile after the faulty group. It appears at a fixed distance of two edges from the closing patch, in a specific subset of the eight output elements. A wrong slot counter or wrong first-patch clear in the accumulators is hidden by one-patch groups. It appears only in multi-patch groups, or in a group that follows a refused stride-2 patch, as a sum that is short by one channel or carries a term from the previous group. Handshake state errors appear within one or two cycles as a changed or dropped held output, a missing flag pulse, or in_ready staying high while both internal stages are full.

// File: rtl/wino_pkg.sv
// Package: shared geometry of the 2x2-output, 3x3-kernel minimal-filter tile.
// Assumes square tiles stored row-major in flat vectors.
package wino_pkg;
    localparam int TILE_SIDE  = 4;
    localparam int TILE_ELEMS = TILE_SIDE * TILE_SIDE;
    localparam int OUT_SIDE   = 2;
    localparam int OUT_ELEMS  = OUT_SIDE * OUT_SIDE;
    localparam int KERN_SIDE  = 3;
endpackage

// File: rtl/wino_in_xform.sv
// Module: input transform V = Bt * d * B on one 4x4 patch, adders only.
// Assumes signed DW-bit elements, row-major; output elements are DW+2 bits,
// which covers the growth of two add stages.
module wino_in_xform
    import wino_pkg::*;
#(
    parameter int DW = 16,
    parameter int VW = DW + 2
) (
    input  logic [TILE_ELEMS*DW-1:0] tile_i,
    output logic [TILE_ELEMS*VW-1:0] v_o
);
    localparam int TW = DW + 1;

    logic signed [DW-1:0] d [TILE_ELEMS];
    logic signed [TW-1:0] t [TILE_ELEMS];
    logic signed [VW-1:0] v [TILE_ELEMS];

    for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_unpack
        assign d[k] = tile_i[k*DW +: DW];
        assign v_o[k*VW +: VW] = v[k];
    end

    // Row pass: combine patch rows per column (Bt applied from the left).
    for (genvar c = 0; c < TILE_SIDE; c++) begin : g_rows
        assign t[0*4+c] = TW'(d[0*4+c]) - TW'(d[2*4+c]);
        assign t[1*4+c] = TW'(d[1*4+c]) + TW'(d[2*4+c]);
        assign t[2*4+c] = TW'(d[2*4+c]) - TW'(d[1*4+c]);
        assign t[3*4+c] = TW'(d[1*4+c]) - TW'(d[3*4+c]);
    end

    // Column pass: combine columns per row (B applied from the right).
    for (genvar r = 0; r < TILE_SIDE; r++) begin : g_cols
        assign v[r*4+0] = VW'(t[r*4+0]) - VW'(t[r*4+2]);
        assign v[r*4+1] = VW'(t[r*4+1]) + VW'(t[r*4+2]);
        assign v[r*4+2] = VW'(t[r*4+2]) - VW'(t[r*4+1]);
        assign v[r*4+3] = VW'(t[r*4+1]) - VW'(t[r*4+3]);
    end
endmodule

// File: rtl/wino_out_xform.sv
// Module: output transform Y = At * M * A on one lane's 4x4 accumulator tile,
// then an arithmetic shift by FRAC_BITS and a clamp to DW bits.
// Assumes AW-bit signed accumulators; the adder tree grows by 4 bits.
module wino_out_xform
    import wino_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 40,
    parameter int FRAC_BITS = 0
) (
    input  logic [TILE_ELEMS*AW-1:0] m_i,
    output logic [OUT_ELEMS*DW-1:0]  y_o
);
    localparam int SW = AW + 2;
    localparam int ZW = AW + 4;
    localparam logic signed [ZW-1:0] HI = ZW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [ZW-1:0] LO = -HI - ZW'(1);

    logic signed [AW-1:0] m  [TILE_ELEMS];
    logic signed [SW-1:0] s  [OUT_SIDE*TILE_SIDE];
    logic signed [ZW-1:0] z  [OUT_ELEMS];
    logic signed [ZW-1:0] zs [OUT_ELEMS];

    for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_unpack
        assign m[k] = m_i[k*AW +: AW];
    end

    // Row pass: two output rows from four accumulator rows.
    for (genvar c = 0; c < TILE_SIDE; c++) begin : g_rows
        assign s[0*4+c] = SW'(m[0*4+c]) + SW'(m[1*4+c]) + SW'(m[2*4+c]);
        assign s[1*4+c] = SW'(m[1*4+c]) - SW'(m[2*4+c]) - SW'(m[3*4+c]);
    end

    // Column pass, rescale and clamp for each of the four results.
    for (genvar r = 0; r < OUT_SIDE; r++) begin : g_cols
        assign z[r*2+0] = ZW'(s[r*4+0]) + ZW'(s[r*4+1]) + ZW'(s[r*4+2]);
        assign z[r*2+1] = ZW'(s[r*4+1]) - ZW'(s[r*4+2]) - ZW'(s[r*4+3]);
    end

    for (genvar k = 0; k < OUT_ELEMS; k++) begin : g_sat
        assign zs[k] = z[k] >>> FRAC_BITS;
        assign y_o[k*DW +: DW] = (zs[k] > HI) ? HI[DW-1:0] :
                                 (zs[k] < LO) ? LO[DW-1:0] : zs[k][DW-1:0];
    end
endmodule

// File: rtl/wino_lane.sv
// Module: one output-channel lane. Holds CIN_MAX transformed weight tiles,
// multiplies the shared transformed patch element-wise with the tile of the
// current channel slot and accumulates the 16 products.
// Assumes go_i pulses once per patch; first_i clears the running sums.
module wino_lane
    import wino_pkg::*;
#(
    parameter int DW      = 16,
    parameter int VW      = DW + 2,
    parameter int AW      = 40,
    parameter int CIN_MAX = 4,
    parameter int CB      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     w_we,
    input  logic [CB-1:0]            w_chan,
    input  logic [TILE_ELEMS*DW-1:0] w_tile,
    input  logic                     go_i,
    input  logic                     first_i,
    input  logic [CB-1:0]            chan_i,
    input  logic [TILE_ELEMS*VW-1:0] v_i,
    output logic [TILE_ELEMS*AW-1:0] acc_o
);
    localparam int PW = VW + DW;

    logic signed [DW-1:0] wmem [CIN_MAX][TILE_ELEMS];

    // Weight store: one whole transformed tile per write.
    always_ff @(posedge clk) begin
        if (w_we) begin
            for (int k = 0; k < TILE_ELEMS; k++) begin
                wmem[w_chan][k] <= w_tile[k*DW +: DW];
            end
        end
    end

    for (genvar k = 0; k < TILE_ELEMS; k++) begin : g_el
        logic signed [VW-1:0] v_el;
        logic signed [DW-1:0] u_el;
        logic signed [PW-1:0] prod;
        logic signed [AW-1:0] acc_q;

        assign v_el = v_i[k*VW +: VW];
        assign u_el = wmem[chan_i][k];
        assign prod = v_el * u_el;
        assign acc_o[k*AW +: AW] = acc_q;

        // Running sum over channels; restarts on the first patch of a group.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (go_i) begin
                acc_q <= first_i ? AW'(prod) : acc_q + AW'(prod);
            end
        end
    end
endmodule

// File: rtl/wino_tile_engine.sv
// Module: top of the minimal-filter 3x3 tile engine. Stage V registers the
// transformed patch, stage M accumulates in every lane, and the output
// register holds the clamped 2x2 tiles of all lanes.
// Assumes stride-1 patches stepped by 2 and offline-transformed weights;
// a stride-2 patch is consumed, dropped and flagged.
module wino_tile_engine
    import wino_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LANES     = 2,
    parameter int CIN_MAX   = 4,
    parameter int GUARD     = 2,
    parameter int FRAC_BITS = 0,
    localparam int CB = (CIN_MAX > 1) ? $clog2(CIN_MAX) : 1,
    localparam int LB = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [TILE_ELEMS*DW-1:0]    in_tile,
    input  logic                        in_last,
    input  logic                        in_stride2,
    input  logic                        w_we,
    input  logic [LB-1:0]               w_lane,
    input  logic [CB-1:0]               w_chan,
    input  logic [TILE_ELEMS*DW-1:0]    w_tile,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [LANES*OUT_ELEMS*DW-1:0] out_tile,
    output logic                        stride_err
);
    localparam int VW = DW + 2;
    localparam int AW = VW + DW + CB + GUARD;
    localparam int OW = LANES * OUT_ELEMS * DW;
    localparam logic [CB-1:0] CHAN_TOP = CB'(CIN_MAX - 1);

    logic                     accept, take;
    logic                     b_go, fin_clr;
    logic [TILE_ELEMS*VW-1:0] v_comb;
    logic [TILE_ELEMS*VW-1:0] v_q;
    logic                     v_vld, v_last;
    logic [CB-1:0]            v_chan, chan_q;
    logic                     fin_q;
    logic [OW-1:0]            y_all, out_q;
    logic                     out_vld_q, err_q;

    assign accept   = in_valid && in_ready;
    assign take     = accept && !in_stride2;
    assign fin_clr  = fin_q && (!out_vld_q || out_ready);
    assign b_go     = v_vld && (!fin_q || fin_clr);
    assign in_ready = !v_vld || b_go;

    assign out_valid  = out_vld_q;
    assign out_tile   = out_q;
    assign stride_err = err_q;

    wino_in_xform #(.DW(DW), .VW(VW)) u_in (
        .tile_i (in_tile),
        .v_o    (v_comb)
    );

    // Channel-slot counter: position of the next stride-1 patch in its group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (take) begin
            if (in_last)                chan_q <= '0;
            else if (chan_q != CHAN_TOP) chan_q <= chan_q + CB'(1);
        end
    end

    // Stage V: register the transformed patch and its group tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_vld  <= 1'b0;
            v_q    <= '0;
            v_last <= 1'b0;
            v_chan <= '0;
        end else if (in_ready) begin
            v_vld <= take;
            if (take) begin
                v_q    <= v_comb;
                v_last <= in_last;
                v_chan <= chan_q;
            end
        end
    end

    // Refused-stride flag: one-cycle pulse after a stride-2 patch is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && in_stride2;
    end

    // Group-finished marker: accumulators hold a full group awaiting output.
    always_ff @(posedge clk) begin
        if (!rst_n)                fin_q <= 1'b0;
        else if (b_go && v_last)   fin_q <= 1'b1;
        else if (fin_clr)          fin_q <= 1'b0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [TILE_ELEMS*AW-1:0] acc;
        logic                     lane_we;

        assign lane_we = w_we && (w_lane == LB'(l));

        wino_lane #(
            .DW(DW), .VW(VW), .AW(AW), .CIN_MAX(CIN_MAX), .CB(CB)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .w_we    (lane_we),
            .w_chan  (w_chan),
            .w_tile  (w_tile),
            .go_i    (b_go),
            .first_i (v_chan == '0),
            .chan_i  (v_chan),
            .v_i     (v_q),
            .acc_o   (acc)
        );

        wino_out_xform #(.DW(DW), .AW(AW), .FRAC_BITS(FRAC_BITS)) u_out (
            .m_i (acc),
            .y_o (y_all[l*OUT_ELEMS*DW +: OUT_ELEMS*DW])
        );
    end

    // Output register: load a finished group, otherwise drain on out_ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            out_q     <= '0;
        end else if (fin_clr) begin
            out_vld_q <= 1'b1;
            out_q     <= y_all;
        end else if (out_ready) begin
            out_vld_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wino_tile_engine_chk.sv
// Module: protocol checker bound into the tile engine.
// Assumes the clock and reset of the engine; observes ports and the
// group-finished marker.
module wino_tile_engine_chk #(
    parameter int OW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_stride2,
    input logic          out_valid,
    input logic          out_ready,
    input logic [OW-1:0] out_tile,
    input logic          stride_err,
    input logic          fin_q
);
    // R1: outputs are quiet on the first cycle out of reset.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && !stride_err));

    // R7: a blocked output is held unchanged.
    p_hold_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tile)));

    // R7: a finished group waits while the output is blocked.
    p_fin_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && out_valid && !out_ready) |=> fin_q);

    // R6: a refused stride-2 patch raises the flag next cycle.
    p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_stride2) |=> stride_err);

    // R6: the flag has no other cause.
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stride_err |-> $past(in_valid && in_ready && in_stride2));

    // R3: a new output only follows a finished group.
    p_out_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fin_q));
endmodule

bind wino_tile_engine wino_tile_engine_chk #(.OW(LANES*4*DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_stride2 (in_stride2),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tile   (out_tile),
    .stride_err (stride_err),
    .fin_q      (fin_q)
);

// File: tb/sim_wino_tile_engine.sv
module sim_wino_tile_engine;
    localparam int CLK_T  = 10;
    localparam int NVEC   = 6;
    localparam int VEC [NVEC][2] = '{
        '{11, 1}, '{23, 2}, '{37, 3}, '{41, 4}, '{59, 2}, '{73, 1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [255:0] in_tile = '0;
    logic         in_last = 1'b0;
    logic         in_stride2 = 1'b0;
    logic         w_we = 1'b0;
    logic [0:0]   w_lane = '0;
    logic [1:0]   w_chan = '0;
    logic [255:0] w_tile = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_tile;
    logic         stride_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int dat [6][16];
    int ker [2][4][9];

    always #(CLK_T/2) clk = ~clk;

    wino_tile_engine #(.FRAC_BITS(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tile(in_tile), .in_last(in_last), .in_stride2(in_stride2),
        .w_we(w_we), .w_lane(w_lane), .w_chan(w_chan), .w_tile(w_tile),
        .out_valid(out_valid), .out_ready(out_ready), .out_tile(out_tile),
        .stride_err(stride_err)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd(inout int unsigned s, input int span);
        s = s * 32'd1103515245 + 32'd12345;
        return int'((s >> 16) % unsigned'(2*span+1)) - span;
    endfunction

    // Direct spatial correlation over n channels starting at patch d0, clamped.
    function automatic int expv(int l, int k, int d0, int n);
        int s = 0;
        int r = k / 2;
        int c = k % 2;
        for (int ch = 0; ch < n; ch++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    s += dat[d0+ch][(r+i)*4 + c + j] * ker[l][ch][i*3+j];
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    // Offline kernel transform scaled by 4: (2G) k (2G)^T, integer exact.
    task automatic load_w(int l, int ch);
        int g2 [4][3] = '{'{2,0,0}, '{1,1,1}, '{1,-1,1}, '{0,0,2}};
        @(negedge clk);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++) begin
                int u = 0;
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        u += g2[a][i] * ker[l][ch][i*3+j] * g2[b][j];
                w_tile[(a*4+b)*16 +: 16] = 16'(u);
            end
        w_lane = 1'(l);
        w_chan = 2'(ch);
        w_we   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        w_we = 1'b0;
    endtask

    // Offer one patch at a negedge; return at the negedge after acceptance.
    task automatic send_tile(int t, bit last, bit s2);
        for (int k = 0; k < 16; k++) in_tile[k*16 +: 16] = 16'(dat[t][k]);
        in_last    = last;
        in_stride2 = s2;
        in_valid   = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid   = 1'b0;
        in_stride2 = 1'b0;
        in_last    = 1'b0;
    endtask

    task automatic collect(output logic [127:0] cap, output int waits);
        waits = 0;
        while (!out_valid && waits < 50) begin
            @(negedge clk);
            waits++;
        end
        cap = out_tile;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int lane_el(logic [127:0] cap, int l, int k);
        return int'($signed(cap[(l*4+k)*16 +: 16]));
    endfunction

    task automatic cmp_all(string req, logic [127:0] cap, int d0, int n);
        for (int l = 0; l < 2; l++)
            for (int k = 0; k < 4; k++)
                chk(req, lane_el(cap, l, k), expv(l, k, d0, n));
    endtask

    initial begin
        logic [127:0] cap;
        logic [127:0] held;
        int waits;
        int unsigned sd;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs and ready input after reset
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 stride_err", int'(stride_err), 0);

        // Table walk: one group per entry; R2 for one patch, R3 for several, R4 per lane
        for (int e = 0; e < NVEC; e++) begin
            int n = VEC[e][1];
            sd = unsigned'(VEC[e][0]);
            for (int ch = 0; ch < n; ch++)
                for (int k = 0; k < 16; k++) dat[ch][k] = rnd(sd, 50);
            for (int l = 0; l < 2; l++)
                for (int ch = 0; ch < n; ch++) begin
                    for (int k = 0; k < 9; k++) ker[l][ch][k] = rnd(sd, 20);
                    load_w(l, ch);
                end
            for (int ch = 0; ch < n; ch++) send_tile(ch, ch == n-1, 1'b0);
            collect(cap, waits);
            chk("R8 latency", waits, 2);
            cmp_all((n == 1) ? "R2 R4 single" : "R3 R4 group", cap, 0, n);
        end

        // R5: clamp at both ends
        for (int k = 0; k < 16; k++) dat[0][k] = 1000;
        for (int k = 0; k < 9; k++) begin
            ker[0][0][k] = 1000;
            ker[1][0][k] = -1000;
        end
        load_w(0, 0);
        load_w(1, 0);
        send_tile(0, 1'b1, 1'b0);
        collect(cap, waits);
        for (int k = 0; k < 4; k++) begin
            chk("R5 high clamp", lane_el(cap, 0, k), 32767);
            chk("R5 low clamp", lane_el(cap, 1, k), -32768);
        end

        // R6: refused stride-2 patch between two channels of one group
        sd = 32'd97;
        for (int t = 0; t < 6; t++)
            for (int k = 0; k < 16; k++) dat[t][k] = rnd(sd, 50);
        for (int l = 0; l < 2; l++)
            for (int ch = 0; ch < 2; ch++) begin
                for (int k = 0; k < 9; k++) ker[l][ch][k] = rnd(sd, 20);
                load_w(l, ch);
            end
        send_tile(0, 1'b0, 1'b0);
        send_tile(5, 1'b1, 1'b1);
        chk("R6 flag raised", int'(stride_err), 1);
        @(negedge clk);
        chk("R6 flag one cycle", int'(stride_err), 0);
        chk("R6 no output", int'(out_valid), 0);
        @(negedge clk);
        chk("R6 still no output", int'(out_valid), 0);
        send_tile(1, 1'b1, 1'b0);
        collect(cap, waits);
        cmp_all("R6 group unaffected", cap, 0, 2);

        // R7: blocked output, queued groups, then drain in order (slot 0 weights)
        out_ready = 1'b0;
        send_tile(2, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 held valid", int'(out_valid), 1);
        held = out_tile;
        send_tile(3, 1'b1, 1'b0);
        send_tile(4, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        chk("R7 input stalled", int'(in_ready), 0);
        chk("R7 held stable", int'(out_tile == held), 1);
        out_ready = 1'b1;
        collect(cap, waits);
        cmp_all("R7 first", cap, 2, 1);
        collect(cap, waits);
        cmp_all("R7 second", cap, 3, 1);
        collect(cap, waits);
        cmp_all("R7 third", cap, 4, 1);
        repeat (3) @(negedge clk);
        chk("R7 drained", int'(out_valid), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule